// File: doc/BRIEF.md
# Conditional Branch and Loop Evaluator

This block decides whether a branch is taken and computes the target address. It supports three request kinds. A flag branch tests the condition codes N, Z, V and C against a 4-bit condition selector. A loop branch decrements, increments or only tests a 16-bit counter, then branches on the counter being zero or non-zero. A bit-test branch masks an operand byte and branches when all the selected bits are set, or when all of them are clear.

The decoder upstream presents a request for one cycle, together with the opcode-start address, a length indication and the raw displacement. One clock edge later the block returns the taken flag, the target address, the updated counter and a counter write strobe. The decoder does the opcode decode and fetches the displacement bytes.

Top module: `brl_branch_eval`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid`, `taken`, `counter_we`, `target` and `counter_out` are all zero.
- R2: A request sampled with `req_valid`=1 at a rising edge produces its results, with `rsp_valid`=1, right after that edge. In any cycle with `rsp_valid`=0, both `taken` and `counter_we` are 0.
- R3: When `req_kind`=0 (flag branch), the selector codes behave as follows: 0 is always taken, 1 is never taken, 6 is taken on Z=0, 7 on Z=1, 8 on V=0, 9 on V=1, 10 on N=0 and 11 on N=1.
- R4: Unsigned selector codes: 2 is taken when (C or Z)=0, 3 when (C or Z)=1, 4 when C=0 and 5 when C=1.
- R5: Signed selector codes: 12 is taken when (N xor V)=0, 13 when (N xor V)=1, 14 when (Z or (N xor V))=0 and 15 when (Z or (N xor V))=1.
- R6: For a flag branch, `target` = `op_addr` + 2 + sign-extended `disp[7:0]` when `long_form`=0. It is `op_addr` + 4 + `disp[15:0]` when `long_form`=1. All sums wrap modulo 2^16.
- R7: When `req_kind`=1 (loop), `loop_mode` 0 decrements the counter and 1 increments it; both write the result back (`counter_we`=1) whether the branch is taken or not. Modes 2 and 3 only test: `counter_out` equals `counter_in` and `counter_we`=0.
- R8: A loop branch is taken when the updated counter is zero (`loop_on_nz`=0) or non-zero (`loop_on_nz`=1). Its target is `op_addr` + 3 + sign-extended `disp[8:0]`.
- R9: When `req_kind`=2 (bit test), the branch is taken when (~`bit_operand` & `bit_mask`)==0 if `bit_on_clear`=0, and when (`bit_operand` & `bit_mask`)==0 if `bit_on_clear`=1. An all-zero mask is therefore always taken.
- R10: The bit-test target is `op_addr` + L + sign-extended `disp[7:0]`. L is 4, 5 or 6 for `bit_len` codes 0, 1 and 2; code 3 is treated as 6.
- R11: `req_kind`=3 is reserved. It responds with `taken`=0 and `counter_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 flag, 1 loop, 2 bit test, 3 reserved |
| cond_sel | input | 4 | Flag condition selector |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| long_form | input | 1 | Flag branch is 4 bytes long with a 16-bit offset |
| op_addr | input | 16 | Opcode-start address |
| disp | input | 16 | Raw displacement, low bits used per kind |
| loop_mode | input | 2 | 0 decrement, 1 increment, 2/3 test only |
| loop_on_nz | input | 1 | Loop branches on non-zero instead of zero |
| counter_in | input | 16 | Selected counter value |
| bit_operand | input | 8 | Operand byte for bit test |
| bit_mask | input | 8 | Mask byte for bit test |
| bit_on_clear | input | 1 | Bit test branches when masked bits are clear |
| bit_len | input | 2 | Bit-test instruction length code |
| rsp_valid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| target | output | 16 | Branch target address |
| counter_out | output | 16 | Updated counter value |
| counter_we | output | 1 | Counter write-back strobe |

## Verification
All state in this block sits in one output register stage, so any fault in the decision or address logic shows at the ports one edge after the faulty request. A wrong selector decode shows as a wrong `taken` for some flag pattern. A wrong offset width or wrong length constant shows as a `target` that is off by a fixed step or by a sign-extension error. A stuck strobe register shows as `taken` or `counter_we` staying high in the cycle after the response. The bench sweeps every selector against all 16 flag combinations. It then uses targeted addresses that wrap and offsets whose sign bit is set, so that each of these faults surfaces in the first response it corrupts.

// File: rtl/brl_pkg.sv
// Shared encodings for the branch evaluator.
// Assumes 2-bit kind and loop-mode fields as listed in the brief.
package brl_pkg;
    localparam logic [1:0] KIND_FLAG = 2'd0;
    localparam logic [1:0] KIND_LOOP = 2'd1;
    localparam logic [1:0] KIND_BITS = 2'd2;
    localparam logic [1:0] KIND_NONE = 2'd3;

    localparam logic [1:0] LM_DEC  = 2'd0;
    localparam logic [1:0] LM_INC  = 2'd1;
endpackage

// File: rtl/brl_cond_eval.sv
// Evaluates a 4-bit flag condition selector against N, Z, V, C.
// Purely combinational; the selector encoding is fixed by the brief.
module brl_cond_eval (
    input  logic [3:0] sel,
    input  logic       n,
    input  logic       z,
    input  logic       v,
    input  logic       c,
    output logic       hit
);
    logic sgn_lt;
    logic uns_ls;

    // Shared signed and unsigned terms.
    always_comb begin
        sgn_lt = n ^ v;
        uns_ls = c | z;
    end

    // Select the condition; odd codes are the complement-sense partner.
    always_comb begin
        case (sel)
            4'd0:    hit = 1'b1;
            4'd1:    hit = 1'b0;
            4'd2:    hit = ~uns_ls;
            4'd3:    hit = uns_ls;
            4'd4:    hit = ~c;
            4'd5:    hit = c;
            4'd6:    hit = ~z;
            4'd7:    hit = z;
            4'd8:    hit = ~v;
            4'd9:    hit = v;
            4'd10:   hit = ~n;
            4'd11:   hit = n;
            4'd12:   hit = ~sgn_lt;
            4'd13:   hit = sgn_lt;
            4'd14:   hit = ~(z | sgn_lt);
            default: hit = z | sgn_lt;
        endcase
    end
endmodule

// File: rtl/brl_loop_unit.sv
// Counter update and zero test for loop branches.
// Assumes the caller gates the write strobe by request kind.
module brl_loop_unit #(
    parameter int CNT_W = 16
) (
    input  logic [1:0]       mode,
    input  logic             on_nz,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] cnt_next,
    output logic             we,
    output logic             hit
);
    import brl_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Apply decrement, increment or leave unchanged.
    always_comb begin
        case (mode)
            LM_DEC:  begin cnt_next = cnt_in - ONE; we = 1'b1; end
            LM_INC:  begin cnt_next = cnt_in + ONE; we = 1'b1; end
            default: begin cnt_next = cnt_in;       we = 1'b0; end
        endcase
    end

    // Branch decision on the updated value.
    always_comb hit = on_nz ? (|cnt_next) : ~(|cnt_next);
endmodule

// File: rtl/brl_bit_test.sv
// Mask test for bit-set / bit-clear branches.
// Combinational; an empty mask always satisfies either sense.
module brl_bit_test #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] mask,
    input  logic              on_clear,
    output logic              hit
);
    // Check the masked bits for all-ones or all-zeros.
    always_comb begin
        if (on_clear) hit = ~(|(operand & mask));
        else          hit = ~(|(~operand & mask));
    end
endmodule

// File: rtl/brl_target_calc.sv
// Computes the branch target from opcode address, length and offset.
// Assumes the offset widths are narrower than the address.
module brl_target_calc #(
    parameter int ADDR_W      = 16,
    parameter int SHORT_OFS_W = 8,
    parameter int LOOP_OFS_W  = 9
) (
    input  logic [1:0]        kind,
    input  logic              long_form,
    input  logic [1:0]        bit_len,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [ADDR_W-1:0] disp,
    output logic [ADDR_W-1:0] target
);
    import brl_pkg::*;

    localparam int SHORT_PAD = ADDR_W - SHORT_OFS_W;
    localparam int LOOP_PAD  = ADDR_W - LOOP_OFS_W;

    logic [ADDR_W-1:0] ofs_short;
    logic [ADDR_W-1:0] ofs_loop;
    logic [ADDR_W-1:0] ofs_sel;
    logic [ADDR_W-1:0] step;

    // Sign-extend the two narrow offset forms.
    always_comb begin
        ofs_short = {{SHORT_PAD{disp[SHORT_OFS_W-1]}}, disp[SHORT_OFS_W-1:0]};
        ofs_loop  = {{LOOP_PAD{disp[LOOP_OFS_W-1]}}, disp[LOOP_OFS_W-1:0]};
    end

    // Pick the length step and offset form for the request kind.
    always_comb begin
        case (kind)
            KIND_FLAG: begin
                step    = long_form ? ADDR_W'(4) : ADDR_W'(2);
                ofs_sel = long_form ? disp : ofs_short;
            end
            KIND_LOOP: begin
                step    = ADDR_W'(3);
                ofs_sel = ofs_loop;
            end
            default: begin
                case (bit_len)
                    2'd0:    step = ADDR_W'(4);
                    2'd1:    step = ADDR_W'(5);
                    default: step = ADDR_W'(6);
                endcase
                ofs_sel = ofs_short;
            end
        endcase
    end

    // Modulo-2^ADDR_W sum.
    always_comb target = op_addr + step + ofs_sel;
endmodule

// File: rtl/brl_branch_eval.sv
// Top: branch/loop evaluator with one registered result stage.
// Assumes the request fields are stable in the cycle req_valid is high.
module brl_branch_eval #(
    parameter int ADDR_W      = 16,
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 8,
    parameter int SHORT_OFS_W = 8,
    parameter int LOOP_OFS_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [3:0]        cond_sel,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_v,
    input  logic              flag_c,
    input  logic              long_form,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [ADDR_W-1:0] disp,
    input  logic [1:0]        loop_mode,
    input  logic              loop_on_nz,
    input  logic [CNT_W-1:0]  counter_in,
    input  logic [DATA_W-1:0] bit_operand,
    input  logic [DATA_W-1:0] bit_mask,
    input  logic              bit_on_clear,
    input  logic [1:0]        bit_len,
    output logic              rsp_valid,
    output logic              taken,
    output logic [ADDR_W-1:0] target,
    output logic [CNT_W-1:0]  counter_out,
    output logic              counter_we
);
    import brl_pkg::*;

    logic              cond_hit;
    logic              loop_hit;
    logic              bits_hit;
    logic              loop_we;
    logic [CNT_W-1:0]  loop_cnt;
    logic [ADDR_W-1:0] tgt_c;
    logic              taken_c;
    logic              we_c;
    logic [CNT_W-1:0]  cnt_c;

    brl_cond_eval u_cond (
        .sel (cond_sel),
        .n   (flag_n),
        .z   (flag_z),
        .v   (flag_v),
        .c   (flag_c),
        .hit (cond_hit)
    );

    brl_loop_unit #(.CNT_W(CNT_W)) u_loop (
        .mode     (loop_mode),
        .on_nz    (loop_on_nz),
        .cnt_in   (counter_in),
        .cnt_next (loop_cnt),
        .we       (loop_we),
        .hit      (loop_hit)
    );

    brl_bit_test #(.DATA_W(DATA_W)) u_bits (
        .operand  (bit_operand),
        .mask     (bit_mask),
        .on_clear (bit_on_clear),
        .hit      (bits_hit)
    );

    brl_target_calc #(
        .ADDR_W      (ADDR_W),
        .SHORT_OFS_W (SHORT_OFS_W),
        .LOOP_OFS_W  (LOOP_OFS_W)
    ) u_tgt (
        .kind      (req_kind),
        .long_form (long_form),
        .bit_len   (bit_len),
        .op_addr   (op_addr),
        .disp      (disp),
        .target    (tgt_c)
    );

    // Merge the per-kind decisions.
    always_comb begin
        taken_c = 1'b0;
        we_c    = 1'b0;
        cnt_c   = counter_in;
        case (req_kind)
            KIND_FLAG: taken_c = cond_hit;
            KIND_LOOP: begin
                taken_c = loop_hit;
                we_c    = loop_we;
                cnt_c   = loop_cnt;
            end
            KIND_BITS: taken_c = bits_hit;
            default:   taken_c = 1'b0;
        endcase
    end

    // Result register; strobes drop when no request was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            taken       <= 1'b0;
            counter_we  <= 1'b0;
            target      <= '0;
            counter_out <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                taken       <= taken_c;
                counter_we  <= we_c;
                target      <= tgt_c;
                counter_out <= cnt_c;
            end else begin
                taken      <= 1'b0;
                counter_we <= 1'b0;
            end
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_STROBES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!taken && !counter_we)); // R2
    AST_SHORT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_FLAG && !long_form) |=>
        target == $past(op_addr) + ADDR_W'(2)
                  + {{(ADDR_W-SHORT_OFS_W){$past(disp[SHORT_OFS_W-1])}},
                     $past(disp[SHORT_OFS_W-1:0])}); // R6
    AST_INC_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_LOOP && loop_mode == LM_INC) |=>
        (counter_we && counter_out == $past(counter_in) + CNT_W'(1))); // R7
    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_LOOP && loop_mode[1]) |=>
        (!counter_we && counter_out == $past(counter_in))); // R7
    AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_NONE) |=> (!taken && !counter_we)); // R11
endmodule

// File: tb/tb_brl_branch_eval.sv
module tb_brl_branch_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [3:0]  cond_sel = 4'd0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
    logic        long_form = 1'b0;
    logic [15:0] op_addr = 16'h0;
    logic [15:0] disp = 16'h0;
    logic [1:0]  loop_mode = 2'd0;
    logic        loop_on_nz = 1'b0;
    logic [15:0] counter_in = 16'h0;
    logic [7:0]  bit_operand = 8'h0;
    logic [7:0]  bit_mask = 8'h0;
    logic        bit_on_clear = 1'b0;
    logic [1:0]  bit_len = 2'd0;
    logic        rsp_valid, taken, counter_we;
    logic [15:0] target, counter_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    brl_branch_eval dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .cond_sel(cond_sel), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .flag_c(flag_c), .long_form(long_form), .op_addr(op_addr), .disp(disp),
        .loop_mode(loop_mode), .loop_on_nz(loop_on_nz), .counter_in(counter_in),
        .bit_operand(bit_operand), .bit_mask(bit_mask), .bit_on_clear(bit_on_clear),
        .bit_len(bit_len), .rsp_valid(rsp_valid), .taken(taken), .target(target),
        .counter_out(counter_out), .counter_we(counter_we)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present one request for a single edge; return at the following negedge.
    task automatic fire();
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic bit exp_cond(input logic [3:0] s, input bit n, input bit z,
                                    input bit v, input bit c);
        case (s)
            4'd0: return 1'b1;        4'd1: return 1'b0;
            4'd2: return !(c || z);   4'd3: return c || z;
            4'd4: return !c;          4'd5: return c;
            4'd6: return !z;          4'd7: return z;
            4'd8: return !v;          4'd9: return v;
            4'd10: return !n;         4'd11: return n;
            4'd12: return !(n ^ v);   4'd13: return n ^ v;
            4'd14: return !(z || (n ^ v));
            default: return z || (n ^ v);
        endcase
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "rsp_valid", 16'(rsp_valid), 16'h0);
        check("R1", "taken", 16'(taken), 16'h0);
        check("R1", "counter_we", 16'(counter_we), 16'h0);
        check("R1", "target", target, 16'h0);
        check("R1", "counter_out", counter_out, 16'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_cond_group(input int lo, input int hi, input string tag);
        req_kind = 2'd0; long_form = 1'b0; op_addr = 16'h0400; disp = 16'h0010;
        for (int s = lo; s <= hi; s++) begin
            for (int f = 0; f < 16; f++) begin
                cond_sel = 4'(s);
                {flag_n, flag_z, flag_v, flag_c} = 4'(f);
                fire();
                check(tag, $sformatf("sel %0d flags %b", s, f[3:0]), 16'(taken),
                      16'(exp_cond(4'(s), f[3], f[2], f[1], f[0])));
            end
        end
    endtask

    task automatic t_latency();
        req_kind = 2'd0; cond_sel = 4'd0;
        fire();
        check("R2", "rsp_valid after request", 16'(rsp_valid), 16'h1);
        check("R2", "taken after request", 16'(taken), 16'h1);
        @(negedge clk);
        check("R2", "rsp_valid idle", 16'(rsp_valid), 16'h0);
        check("R2", "taken idle", 16'(taken), 16'h0);
        req_kind = 2'd1; loop_mode = 2'd0; counter_in = 16'h0009;
        fire();
        check("R2", "we on loop", 16'(counter_we), 16'h1);
        @(negedge clk);
        check("R2", "we idle", 16'(counter_we), 16'h0);
    endtask

    task automatic t_flag_targets();
        req_kind = 2'd0; cond_sel = 4'd0;
        long_form = 1'b0; op_addr = 16'h1000; disp = 16'h0080;
        fire(); check("R6", "short negative", target, 16'h0F82);
        disp = 16'hAB05;
        fire(); check("R6", "short ignores upper byte", target, 16'h1007);
        long_form = 1'b1; op_addr = 16'hFFFE; disp = 16'h0010;
        fire(); check("R6", "long wrap", target, 16'h0012);
        op_addr = 16'h8000; disp = 16'hF000;
        fire(); check("R6", "long negative", target, 16'h7004);
    endtask

    task automatic t_loop();
        req_kind = 2'd1; op_addr = 16'h2000; disp = 16'h01F0;
        loop_mode = 2'd0; loop_on_nz = 1'b0; counter_in = 16'h0001;
        fire();
        check("R8", "dec to zero taken", 16'(taken), 16'h1);
        check("R8", "loop target", target, 16'h1FF3);
        check("R7", "dec value", counter_out, 16'h0000);
        check("R7", "dec we", 16'(counter_we), 16'h1);
        counter_in = 16'h0005;
        fire();
        check("R8", "dec not zero", 16'(taken), 16'h0);
        check("R7", "written when not taken", 16'(counter_we), 16'h1);
        check("R7", "dec value 4", counter_out, 16'h0004);
        loop_mode = 2'd1; counter_in = 16'hFFFF; disp = 16'hFE05;
        fire();
        check("R8", "inc wrap to zero taken", 16'(taken), 16'h1);
        check("R7", "inc value", counter_out, 16'h0000);
        check("R8", "9-bit positive offset", target, 16'h2008);
        loop_mode = 2'd2; loop_on_nz = 1'b1; counter_in = 16'h0005;
        fire();
        check("R8", "test nz taken", 16'(taken), 16'h1);
        check("R7", "test no write", 16'(counter_we), 16'h0);
        check("R7", "test unchanged", counter_out, 16'h0005);
        loop_mode = 2'd3; loop_on_nz = 1'b0; counter_in = 16'h0000;
        fire();
        check("R8", "test zero taken", 16'(taken), 16'h1);
        check("R7", "mode 3 no write", 16'(counter_we), 16'h0);
    endtask

    task automatic t_bits();
        req_kind = 2'd2; op_addr = 16'h3000; disp = 16'h00FE; bit_len = 2'd0;
        bit_operand = 8'hF3;
        bit_on_clear = 1'b0; bit_mask = 8'h03;
        fire(); check("R9", "set-test all set", 16'(taken), 16'h1);
        bit_mask = 8'h0C;
        fire(); check("R9", "set-test some clear", 16'(taken), 16'h0);
        bit_on_clear = 1'b1;
        fire(); check("R9", "clear-test all clear", 16'(taken), 16'h1);
        bit_mask = 8'h11;
        fire(); check("R9", "clear-test some set", 16'(taken), 16'h0);
        bit_mask = 8'h00;
        fire(); check("R9", "clear-test empty mask", 16'(taken), 16'h1);
        bit_on_clear = 1'b0;
        fire(); check("R9", "set-test empty mask", 16'(taken), 16'h1);
        fire(); check("R10", "len code 0", target, 16'h3002);
        bit_len = 2'd1;
        fire(); check("R10", "len code 1", target, 16'h3003);
        bit_len = 2'd2;
        fire(); check("R10", "len code 2", target, 16'h3004);
        bit_len = 2'd3;
        fire(); check("R10", "len code 3", target, 16'h3004);
    endtask

    task automatic t_reserved();
        req_kind = 2'd3; cond_sel = 4'd0; bit_mask = 8'h00;
        loop_mode = 2'd0; counter_in = 16'h0001;
        fire();
        check("R11", "rsp_valid", 16'(rsp_valid), 16'h1);
        check("R11", "taken", 16'(taken), 16'h0);
        check("R11", "counter_we", 16'(counter_we), 16'h0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_cond_group(0, 1, "R3");
        t_cond_group(6, 11, "R3");
        t_cond_group(2, 5, "R4");
        t_cond_group(12, 15, "R5");
        t_flag_targets();
        t_loop();
        t_bits();
        t_reserved();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule